// File: doc/BRIEF.md
# Sideband Time and Temperature Responder

This block serves two read-only services on an out-of-band message channel: the current die temperature and the platform date and time. It keeps a one-byte temperature copy, refreshed from a thermal-sensor input on a fixed tick period. The nominal period is one millisecond. It also keeps a snapshot of seven time/date bytes and three format flags, taken from a real-time-clock input on a second fixed period.

A requester presents a one-byte destination address with a valid/ready handshake. When the address names one of the two services, the block streams back a posted response over a byte-wide valid/ready channel. The response is a fixed tag byte, then a payload length byte, then the payload. A last flag marks the final byte. An address that names neither service produces no response and bumps a saturating error counter.

Both snapshots are frozen while a response is on the wire, so every byte of a packet comes from one capture. A period that expires during a response is remembered, and its capture is taken as soon as the stream goes idle.

Top module: `oob_time_temp_responder`

## Requirements
- R1: While reset is high and on the first cycle after it, rsp_valid is 0 and err_count is 0; req_ready is 1 once reset is released.
- R2: A request accepted with req_addr equal to TEMP_ADDR yields exactly three bytes: RESP_TAG, then 8'h01, then the held temperature. rsp_last is 1 on the third byte only.
- R3: The held temperature is reloaded from temp_in once every TEMP_PERIOD clock cycles, so a value held on temp_in for longer than that period is the one reported.
- R4: A request accepted with req_addr equal to TIME_ADDR yields exactly ten bytes: RESP_TAG, 8'h08, the status byte, then seven time bytes. The time bytes are taken from rtc_time bits [8k+7:8k] for k = 0 to 6 (seconds, minutes, hours, weekday, day of month, month, year). They are forwarded unchanged, including hours bit 7 (the PM marker in 12-hour mode). rsp_last is 1 on the tenth byte only.
- R5: The status byte has bit 0 = rtc_dst (daylight saving already applied), bit 1 = rtc_24h (1: 24-hour hours, 0: 12-hour hours), bit 2 = rtc_bin (1: binary, 0: BCD), and bits 7:3 zero. It is captured in the same snapshot as the time bytes.
- R6: The time/flag snapshot and the held temperature do not change while a response is being streamed. Changes on rtc_time, the flags or temp_in during a response do not appear in that response.
- R7: A snapshot period that expires during a response is deferred. Its capture is taken on the first cycle after the last byte has been accepted, without waiting for the next period.
- R8: A request accepted with any other address produces no response bytes and raises err_count by one, saturating at all ones.
- R9: While rsp_valid is 1 and rsp_ready is 0, rsp_valid, rsp_data and rsp_last hold their values.
- R10: req_ready is 0 while a response is being streamed. A request presented then is not taken and does not change err_count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_in | input | 8 | Live temperature from the sensor |
| rtc_time | input | 56 | Live time bytes, seconds in [7:0] through year in [55:48] |
| rtc_dst | input | 1 | Daylight saving applied flag |
| rtc_24h | input | 1 | Hour format flag |
| rtc_bin | input | 1 | Binary (1) or BCD (0) data mode flag |
| req_valid | input | 1 | Request present |
| req_addr | input | 8 | Request destination address |
| req_ready | output | 1 | Block can take a request (idle) |
| rsp_data | output | 8 | Response byte |
| rsp_valid | output | 1 | Response byte present |
| rsp_last | output | 1 | Final byte of the response |
| rsp_ready | input | 1 | Receiver takes the byte |
| err_count | output | ERR_W | Saturating count of requests with an unknown address |

## Verification
The hardest case to reach is a snapshot period that ends during a response, followed by a request early enough to tell the deferred capture apart from the next periodic one. The bench stalls rsp_ready on the status byte for longer than a full snapshot period and changes the clock inputs at the start of the stall. It then expects the old bytes in that packet. It drains the rest at full rate, requests again within a few cycles, and expects the new bytes. Random rounds mix both services, bad addresses and random back-pressure, and drive the error counter into saturation.

// File: rtl/oob_resp_pkg.sv
package oob_resp_pkg;

    localparam int TIME_BYTES = 7;
    localparam int FLAG_BITS  = 3;
    localparam int SNAP_W     = 8 * TIME_BYTES + FLAG_BITS;

    typedef enum logic {
        SVC_TEMP = 1'b0,
        SVC_TIME = 1'b1
    } svc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } stream_e;

    typedef struct packed {
        logic bin;
        logic h24;
        logic dst;
    } rtc_flags_t;

    // payload bytes that follow the tag and length bytes
    function automatic logic [7:0] payload_len(svc_e s);
        return (s == SVC_TIME) ? 8'(TIME_BYTES + 1) : 8'd1;
    endfunction

    function automatic logic [7:0] status_byte(rtc_flags_t f);
        return {5'b0, f.bin, f.h24, f.dst};
    endfunction

endpackage

// File: rtl/oob_period_sampler.sv
module oob_period_sampler #(
    parameter int W      = 8,
    parameter int PERIOD = 100000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] tick_cnt;
    logic          pending;
    logic          wrap;
    logic          due;

    assign wrap = (tick_cnt == CW'(PERIOD - 1));
    assign due  = wrap || pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
            pending  <= 1'b0;
            q        <= '0;
        end else begin
            tick_cnt <= wrap ? '0 : tick_cnt + 1'b1;
            if (due && !hold) begin
                q       <= d;
                pending <= 1'b0;
            end else if (due) begin
                pending <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/oob_resp_framer.sv
module oob_resp_framer
    import oob_resp_pkg::*;
#(
    parameter logic [7:0] TEMP_ADDR = 8'h21,
    parameter logic [7:0] TIME_ADDR = 8'h22,
    parameter logic [7:0] RESP_TAG  = 8'hC3,
    parameter int         ERR_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [7:0]        req_addr,
    output logic              req_ready,
    input  logic [7:0]        temp_q,
    input  logic [SNAP_W-1:0] snap_q,
    output logic [7:0]        rsp_data,
    output logic              rsp_valid,
    output logic              rsp_last,
    input  logic              rsp_ready,
    output logic [ERR_W-1:0]  err_count
);
    localparam int TB_N = 8;

    stream_e    state;
    svc_e       svc;
    logic [3:0] idx;
    logic [7:0] tbyte [TB_N];
    rtc_flags_t flags;
    logic [3:0] tsel;
    logic [7:0] plen;

    assign flags = rtc_flags_t'(snap_q[SNAP_W-1 -: FLAG_BITS]);

    for (genvar gi = 0; gi < TB_N; gi++) begin : g_tb
        if (gi < TIME_BYTES) begin : g_byte
            assign tbyte[gi] = snap_q[8*gi +: 8];
        end else begin : g_pad
            assign tbyte[gi] = 8'h00;
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign rsp_valid = (state == ST_SEND);
    assign plen      = payload_len(svc);
    assign rsp_last  = rsp_valid && ({4'b0, idx} == plen + 8'd1);
    assign tsel      = idx - 4'd3;

    always_comb begin
        if (idx == 4'd0)
            rsp_data = RESP_TAG;
        else if (idx == 4'd1)
            rsp_data = plen;
        else if (idx == 4'd2)
            rsp_data = (svc == SVC_TEMP) ? temp_q : status_byte(flags);
        else
            rsp_data = tbyte[tsel[2:0]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            svc       <= SVC_TEMP;
            idx       <= '0;
            err_count <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (req_addr == TEMP_ADDR || req_addr == TIME_ADDR) begin
                            state <= ST_SEND;
                            svc   <= (req_addr == TIME_ADDR) ? SVC_TIME : SVC_TEMP;
                            idx   <= '0;
                        end else if (err_count != {ERR_W{1'b1}}) begin
                            err_count <= err_count + 1'b1;
                        end
                    end
                end
                default: begin
                    if (rsp_ready) begin
                        if (rsp_last) state <= ST_IDLE;
                        else          idx   <= idx + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/oob_time_temp_responder.sv
module oob_time_temp_responder
    import oob_resp_pkg::*;
#(
    parameter int         TEMP_PERIOD = 100000,
    parameter int         SNAP_PERIOD = 100000,
    parameter logic [7:0] TEMP_ADDR   = 8'h21,
    parameter logic [7:0] TIME_ADDR   = 8'h22,
    parameter logic [7:0] RESP_TAG    = 8'hC3,
    parameter int         ERR_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       temp_in,
    input  logic [55:0]      rtc_time,
    input  logic             rtc_dst,
    input  logic             rtc_24h,
    input  logic             rtc_bin,
    input  logic             req_valid,
    input  logic [7:0]       req_addr,
    output logic             req_ready,
    output logic [7:0]       rsp_data,
    output logic             rsp_valid,
    output logic             rsp_last,
    input  logic             rsp_ready,
    output logic [ERR_W-1:0] err_count
);
    logic [7:0]        temp_q;
    logic [SNAP_W-1:0] snap_q;
    logic [SNAP_W-1:0] snap_d;
    rtc_flags_t        flags_in;

    assign flags_in = '{bin: rtc_bin, h24: rtc_24h, dst: rtc_dst};
    assign snap_d   = {flags_in, rtc_time};

    oob_period_sampler #(.W(8), .PERIOD(TEMP_PERIOD)) u_temp (
        .clk (clk),
        .rst (rst),
        .hold(rsp_valid),
        .d   (temp_in),
        .q   (temp_q)
    );

    oob_period_sampler #(.W(SNAP_W), .PERIOD(SNAP_PERIOD)) u_snap (
        .clk (clk),
        .rst (rst),
        .hold(rsp_valid),
        .d   (snap_d),
        .q   (snap_q)
    );

    oob_resp_framer #(
        .TEMP_ADDR(TEMP_ADDR),
        .TIME_ADDR(TIME_ADDR),
        .RESP_TAG (RESP_TAG),
        .ERR_W    (ERR_W)
    ) u_framer (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .req_ready(req_ready),
        .temp_q   (temp_q),
        .snap_q   (snap_q),
        .rsp_data (rsp_data),
        .rsp_valid(rsp_valid),
        .rsp_last (rsp_last),
        .rsp_ready(rsp_ready),
        .err_count(err_count)
    );

endmodule

// File: rtl/oob_resp_checker.sv
module oob_resp_checker
    import oob_resp_pkg::*;
#(
    parameter logic [7:0] RESP_TAG = 8'hC3,
    parameter int         ERR_W    = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic [7:0]        rsp_data,
    input logic              rsp_valid,
    input logic              rsp_last,
    input logic              rsp_ready,
    input logic [ERR_W-1:0]  err_count,
    input logic [7:0]        temp_q,
    input logic [SNAP_W-1:0] snap_q
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!rsp_valid && err_count == '0));

    // R2
    tag_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_valid) |-> (rsp_data == RESP_TAG));

    // R4
    last_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_last |-> rsp_valid);

    // R6
    snap_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(rsp_valid)) |-> ($stable(snap_q) && $stable(temp_q)));

    // R8
    err_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));

    // R9
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_last)));

    // R10
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

endmodule

bind oob_time_temp_responder oob_resp_checker #(
    .RESP_TAG(RESP_TAG),
    .ERR_W   (ERR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_ready(req_ready),
    .rsp_data (rsp_data),
    .rsp_valid(rsp_valid),
    .rsp_last (rsp_last),
    .rsp_ready(rsp_ready),
    .err_count(err_count),
    .temp_q   (temp_q),
    .snap_q   (snap_q)
);

// File: tb/oob_time_temp_responder_test.sv
module oob_time_temp_responder_test;

    localparam int         TP    = 50;
    localparam int         SP    = 40;
    localparam int         EW    = 2;
    localparam logic [7:0] A_TMP = 8'h21;
    localparam logic [7:0] A_TIM = 8'h22;
    localparam logic [7:0] TAG   = 8'hC3;
    localparam int         SETTLE = TP + 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    temp_in = '0;
    logic [55:0]   rtc_time = '0;
    logic          rtc_dst = 1'b0, rtc_24h = 1'b0, rtc_bin = 1'b0;
    logic          req_valid = 1'b0;
    logic [7:0]    req_addr = '0;
    logic          req_ready;
    logic [7:0]    rsp_data;
    logic          rsp_valid, rsp_last;
    logic          rsp_ready = 1'b0;
    logic [EW-1:0] err_count;

    oob_time_temp_responder #(
        .TEMP_PERIOD(TP), .SNAP_PERIOD(SP), .TEMP_ADDR(A_TMP),
        .TIME_ADDR(A_TIM), .RESP_TAG(TAG), .ERR_W(EW)
    ) uut (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int exp_err = 0;
    logic [7:0] got [16];
    int  got_n;
    int  last_pos;
    int  last_cnt;
    bit  done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                check(0, "WDOG", "watchdog expired", cyc, 150000);
                summary();
            end
        end
    end

    function automatic logic [7:0] exp_byte(input bit is_time, input int i,
                                            input logic [7:0] t, input logic [55:0] tm,
                                            input logic [2:0] fl);
        if (i == 0) return TAG;
        if (i == 1) return is_time ? 8'd8 : 8'd1;
        if (i == 2) return is_time ? {5'b0, fl} : t;
        return tm[8*(i-3) +: 8];
    endfunction

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_req(input logic [7:0] a, output bit taken);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        taken     = req_ready;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // collects one response; optional stall before byte stall_idx with an rtc change
    task automatic collect(input int stall_idx, input int stall_len, input bit do_chg,
                           input logic [55:0] chg, input bit rnd);
        int guard = 0;
        int stalled = 0;
        bit pv = 0;
        logic [7:0] pd = '0;
        logic pl = 0;
        got_n = 0; last_pos = -1; last_cnt = 0;
        while (guard < 3000) begin
            @(negedge clk);
            guard++;
            if (pv) begin
                // R9: data held under back-pressure
                check(rsp_valid && rsp_data == pd && rsp_last == pl, "R9",
                      "held byte", rsp_data, pd);
            end
            if (got_n == stall_idx && stalled < stall_len) begin
                rsp_ready = 1'b0;
                stalled++;
                if (stalled == 1 && do_chg) rtc_time = chg;
            end else begin
                rsp_ready = rnd ? (($urandom % 100) < 70) : 1'b1;
            end
            pv = rsp_valid && !rsp_ready;
            pd = rsp_data; pl = rsp_last;
            if (rsp_valid && rsp_ready) begin
                if (got_n < 16) got[got_n] = rsp_data;
                if (rsp_last) begin last_pos = got_n; last_cnt++; end
                got_n++;
                if (rsp_last) begin
                    @(negedge clk);
                    rsp_ready = 1'b0;
                    break;
                end
            end
        end
    endtask

    task automatic check_frame(input string req, input bit is_time, input logic [7:0] t,
                               input logic [55:0] tm, input logic [2:0] fl);
        int n = is_time ? 10 : 3;
        check(got_n == n, req, "byte count", got_n, n);
        check(last_pos == n - 1 && last_cnt == 1, req, "last position", last_pos, n - 1);
        for (int i = 0; i < n && i < got_n; i++)
            check(got[i] == exp_byte(is_time, i, t, tm, fl), req, $sformatf("byte %0d", i),
                  got[i], exp_byte(is_time, i, t, tm, fl));
    endtask

    task automatic bad_req(input logic [7:0] a, input string req);
        bit tk;
        bit seen = 0;
        send_req(a, tk);
        if (tk && exp_err < (1 << EW) - 1) exp_err++;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (rsp_valid) seen = 1;
        end
        check(!seen, req, "no response on bad address", seen, 0);
        check(err_count == EW'(exp_err), req, "err_count", err_count, exp_err);
    endtask

    initial begin
        bit tk;
        void'($urandom(32'd1234));
        wait_cyc(3);
        // R1
        check(!rsp_valid && err_count == '0, "R1", "in reset", {rsp_valid, err_count}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!rsp_valid && err_count == '0 && req_ready, "R1", "after reset",
              {rsp_valid, err_count, req_ready}, 1);

        // R2 R3: temperature service
        temp_in = 8'h3A;
        wait_cyc(SETTLE);
        send_req(A_TMP, tk);
        check(tk, "R2", "request taken", tk, 1);
        collect(99, 0, 0, '0, 0);
        check_frame("R2", 0, 8'h3A, '0, 3'b0);
        temp_in = 8'hE1;
        wait_cyc(SETTLE);
        send_req(A_TMP, tk);
        collect(99, 0, 0, '0, 1);
        check_frame("R3", 0, 8'hE1, '0, 3'b0);

        // R4 R5: 12-hour PM hours, BCD, daylight saving set
        rtc_time = 56'h25_07_19_03_92_45_30;
        rtc_dst = 1; rtc_24h = 0; rtc_bin = 0;
        wait_cyc(SETTLE);
        send_req(A_TIM, tk);
        collect(99, 0, 0, '0, 0);
        check_frame("R4", 1, 8'hE1, 56'h25_07_19_03_92_45_30, 3'b001);
        rtc_dst = 0; rtc_24h = 1; rtc_bin = 1;
        wait_cyc(SETTLE);
        send_req(A_TIM, tk);
        collect(99, 0, 0, '0, 1);
        check_frame("R5", 1, 8'hE1, 56'h25_07_19_03_92_45_30, 3'b110);

        // R6 R7: change during a long stall, then re-request quickly
        rtc_time = 56'h11_22_33_44_55_66_77;
        wait_cyc(SETTLE);
        send_req(A_TIM, tk);
        collect(2, SP + 12, 1, 56'h01_02_03_04_05_06_07, 0);
        check_frame("R6", 1, 8'hE1, 56'h11_22_33_44_55_66_77, 3'b110);
        wait_cyc(2);
        send_req(A_TIM, tk);
        collect(99, 0, 0, '0, 0);
        check_frame("R7", 1, 8'hE1, 56'h01_02_03_04_05_06_07, 3'b110);

        // R10: request while streaming is not taken and not counted
        send_req(A_TMP, tk);
        wait_cyc(1);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 8'h99;
        check(!req_ready && rsp_valid, "R10", "req_ready while busy", req_ready, 0);
        wait_cyc(3);
        req_valid = 1'b0;
        check(err_count == EW'(exp_err), "R10", "err unchanged", err_count, exp_err);
        collect(99, 0, 0, '0, 0);
        check_frame("R10", 0, 8'hE1, '0, 3'b0);

        // R8: bad addresses up to saturation
        for (int i = 0; i < 5; i++) bad_req(8'h00 + 8'(i), "R8");

        // random rounds
        for (int it = 0; it < 24; it++) begin
            int k = $urandom % 3;
            logic [7:0]  t  = 8'($urandom);
            logic [55:0] tm = {24'($urandom), 32'($urandom)};
            logic [2:0]  fl = 3'($urandom);
            temp_in = t; rtc_time = tm;
            {rtc_bin, rtc_24h, rtc_dst} = fl;
            wait_cyc(SETTLE);
            if (k == 2) begin
                logic [7:0] a = 8'($urandom);
                if (a == A_TMP || a == A_TIM) a = 8'hF0;
                bad_req(a, "R8");
            end else begin
                send_req(k == 1 ? A_TIM : A_TMP, tk);
                collect(99, 0, 0, '0, 1);
                check_frame(k == 1 ? "R4" : "R2", k == 1, t, tm, fl);
            end
        end

        done = 1;
        summary();
    end

endmodule